// File: doc/BRIEF.md
# ChaCha Keystream Block Engine

This block produces ChaCha keystream one 512-bit block at a time and combines it with a 512-bit data word by XOR. A 16-word working state is filled from fixed constants, the key, a 64-bit block counter and a 64-bit IV. It then goes through a run-time selected number of rounds. Four quarterround units run side by side, so each clock finishes one whole column round or one whole diagonal round. After the last round, each working word is added to its starting value and the sum is XORed with the data word.

The surrounding logic presents the key, IV and data on the ports and holds them steady until the result appears, because none of them is captured inside. A pulse on `init_i` starts a message and loads the block counter from `ctr_init_i`. Each later pulse on `next_i` produces the following block, with the counter advanced by one. `ready_o` shows when a strobe will be taken. `valid_o` marks the registered result on `data_o`.

Top module: `chacha_core`

## Requirements
- R1: After reset, `ready_o` is 1, `valid_o` is 0 and `data_o` is all zeros.
- R2: Each 32-bit word of state, data and result is little-endian: word i sits at bits [32i+31:32i], and its first byte is bits [32i+7:32i]. With `key256_i`=1, words 0..3 hold 0x61707865, 0x3320646e, 0x79622d32 and 0x6b206574, and words 4..11 hold `key_i` word 0..7. An all-zero key, IV, counter and data at 20 rounds gives result word 0 = 0xade0b876 and word 1 = 0x903df1a0.
- R3: With `key256_i`=0, words 0..3 hold 0x61707865, 0x3120646e, 0x79622d36 and 0x6b206574. Words 4..7 and also words 8..11 hold `key_i` bits [127:0]. Bits [255:128] have no effect.
- R4: A taken `init_i` loads the block counter from `ctr_init_i`. Counter bits [31:0] go to state word 12 and bits [63:32] to word 13. IV bits [31:0] go to word 14 and bits [63:32] to word 15.
- R5: A taken `next_i` without `init_i` advances the block counter by one, modulo 2^64.
- R6: `rounds_i` values 2, 4, ..., 32 set the round count. Rounds alternate, starting with a column round (quarterrounds on words {i, i+4, i+8, i+12}) and then a diagonal round (words {i, 4+(i+1)%4, 8+(i+2)%4, 12+(i+3)%4}).
- R7: A `rounds_i` value of 0, an odd value or a value above 32 runs 8 rounds.
- R8: Result word i is data word i XOR (final working word i + initial word i mod 2^32).
- R9: With N rounds, `valid_o` first reads 1 after the (N+2)th rising edge following the edge that takes the strobe (11 edges in all for N=8). `ready_o` is 0 from the edge that takes the strobe until that edge.
- R10: `valid_o` and `data_o` hold until a strobe is taken. `valid_o` is 0 from the edge that takes the strobe.
- R11: A strobe is taken only while `ready_o` is 1, and strobes at other times have no effect. When `init_i` and `next_i` are both taken together, `init_i` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Start a message, load counter |
| next_i | input | 1 | Produce the following block |
| key256_i | input | 1 | 1: 256-bit key, 0: 128-bit key |
| key_i | input | 256 | Key words, held stable |
| iv_i | input | 64 | IV, held stable |
| ctr_init_i | input | 64 | Counter start value |
| rounds_i | input | ROUND_W (6) | Round count setting |
| data_i | input | 512 | Data word, held stable |
| ready_o | output | 1 | Block idle, strobe will be taken |
| data_o | output | 512 | Data XOR keystream |
| valid_o | output | 1 | `data_o` holds a finished block |

## Verification
Each strobe the driver issues is stored in the scoreboard together with its expected block and its due cycle. The due cycle is the cycle count at the strobe plus the effective round count plus 3. The count is sampled on the falling edge, so it marks the first falling edge after the (N+2)th rising edge that follows the taking edge. The monitor compares both the data and the cycle at the rising edge of `valid_o`. It flags any rise that no taken strobe accounts for, which covers strobes sent while busy. `ready_o` and `valid_o` are checked low on the falling edge right after a taken strobe. Hold behaviour is checked several falling edges after a result, before the next strobe.

// File: rtl/chacha_pkg.sv
package chacha_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned STATE_WORDS = 16;
  localparam int unsigned QR_UNITS    = 4;
  localparam int unsigned BLOCK_W     = WORD_W * STATE_WORDS;
  localparam int unsigned KEY_W       = 8 * WORD_W;
  localparam int unsigned CTR_W       = 2 * WORD_W;
  localparam int unsigned IV_W        = 2 * WORD_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [STATE_WORDS-1:0][WORD_W-1:0] state_t;
  typedef logic [3:0][WORD_W-1:0] const_t;

  typedef enum logic [1:0] {PH_IDLE, PH_LOAD, PH_ROUND, PH_FINAL} phase_e;

  // index 0 is the first state word
  localparam const_t CONST_K32 = {32'h6b206574, 32'h79622d32, 32'h3320646e, 32'h61707865};
  localparam const_t CONST_K16 = {32'h6b206574, 32'h79622d36, 32'h3120646e, 32'h61707865};

  function automatic word_t rotl(input word_t v, input int unsigned n);
    return (v << n) | (v >> (WORD_W - n));
  endfunction
endpackage

// File: rtl/chacha_qr.sv
module chacha_qr
  import chacha_pkg::*;
(
  input  word_t a_i,
  input  word_t b_i,
  input  word_t c_i,
  input  word_t d_i,
  output word_t a_o,
  output word_t b_o,
  output word_t c_o,
  output word_t d_o
);
  word_t a1, b1, c1, d1, a2, b2, c2, d2;

  always_comb begin
    a1 = a_i + b_i;
    d1 = rotl(d_i ^ a1, 16);
    c1 = c_i + d1;
    b1 = rotl(b_i ^ c1, 12);
    a2 = a1 + b1;
    d2 = rotl(d1 ^ a2, 8);
    c2 = c1 + d2;
    b2 = rotl(b1 ^ c2, 7);
  end

  assign a_o = a2;
  assign b_o = b2;
  assign c_o = c2;
  assign d_o = d2;
endmodule

// File: rtl/chacha_round.sv
module chacha_round
  import chacha_pkg::*;
(
  input  state_t st_i,
  input  logic   diag_i,
  output state_t st_o
);
  localparam int unsigned LANES = QR_UNITS;

  word_t col_w [STATE_WORDS];
  word_t dia_w [STATE_WORDS];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int unsigned IA     = g;
    localparam int unsigned IB_COL = LANES + g;
    localparam int unsigned IC_COL = 2*LANES + g;
    localparam int unsigned ID_COL = 3*LANES + g;
    localparam int unsigned IB_DIA = LANES + (g + 1) % LANES;
    localparam int unsigned IC_DIA = 2*LANES + (g + 2) % LANES;
    localparam int unsigned ID_DIA = 3*LANES + (g + 3) % LANES;

    word_t qb, qc, qd, ra, rb, rc, rd;
    assign qb = diag_i ? st_i[IB_DIA] : st_i[IB_COL];
    assign qc = diag_i ? st_i[IC_DIA] : st_i[IC_COL];
    assign qd = diag_i ? st_i[ID_DIA] : st_i[ID_COL];

    chacha_qr u_qr (
      .a_i(st_i[IA]), .b_i(qb), .c_i(qc), .d_i(qd),
      .a_o(ra), .b_o(rb), .c_o(rc), .d_o(rd)
    );

    assign col_w[IA]     = ra;
    assign col_w[IB_COL] = rb;
    assign col_w[IC_COL] = rc;
    assign col_w[ID_COL] = rd;
    assign dia_w[IA]     = ra;
    assign dia_w[IB_DIA] = rb;
    assign dia_w[IC_DIA] = rc;
    assign dia_w[ID_DIA] = rd;
  end

  for (genvar w = 0; w < STATE_WORDS; w++) begin : g_out
    assign st_o[w] = diag_i ? dia_w[w] : col_w[w];
  end
endmodule

// File: rtl/chacha_ctrl.sv
module chacha_ctrl
  import chacha_pkg::*;
#(
  parameter int unsigned ROUND_W    = 6,
  parameter int unsigned MAX_ROUNDS = 32,
  parameter int unsigned DEF_ROUNDS = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               init_i,
  input  logic               next_i,
  input  logic [ROUND_W-1:0] rounds_i,
  input  logic [CTR_W-1:0]   ctr_init_i,
  output logic               ready_o,
  output logic               load_o,
  output logic               step_o,
  output logic               final_o,
  output logic               diag_o,
  output logic [CTR_W-1:0]   ctr_o
);
  localparam logic [ROUND_W-1:0] MAX_R = ROUND_W'(MAX_ROUNDS);
  localparam logic [ROUND_W-1:0] DEF_R = ROUND_W'(DEF_ROUNDS);
  localparam logic [ROUND_W-1:0] ONE_R = ROUND_W'(1);

  phase_e             phase_q;
  logic [ROUND_W-1:0] rnd_q, nrnd_q, rnd_eff;
  logic [CTR_W-1:0]   ctr_q;
  logic               accept, last_rnd;

  assign accept   = ready_o & (init_i | next_i);
  assign rnd_eff  = (rounds_i != '0 && !rounds_i[0] && rounds_i <= MAX_R) ? rounds_i : DEF_R;
  assign last_rnd = (rnd_q == nrnd_q - ONE_R);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      rnd_q   <= '0;
      nrnd_q  <= DEF_R;
      ctr_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (accept) begin
          phase_q <= PH_LOAD;
          nrnd_q  <= rnd_eff;
          ctr_q   <= init_i ? ctr_init_i : ctr_q + CTR_W'(1);
        end
        PH_LOAD: begin
          phase_q <= PH_ROUND;
          rnd_q   <= '0;
        end
        PH_ROUND: begin
          rnd_q <= rnd_q + ONE_R;
          if (last_rnd) phase_q <= PH_FINAL;
        end
        PH_FINAL: phase_q <= PH_IDLE;
        default:  phase_q <= PH_IDLE;
      endcase
    end
  end

  assign ready_o = (phase_q == PH_IDLE);
  assign load_o  = (phase_q == PH_LOAD);
  assign step_o  = (phase_q == PH_ROUND);
  assign final_o = (phase_q == PH_FINAL);
  assign diag_o  = rnd_q[0];  // first round is a column round
  assign ctr_o   = ctr_q;

  a_r4_ctr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && init_i) |=> (ctr_o == $past(ctr_init_i)));
  a_r5_ctr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !init_i) |=> (ctr_o == $past(ctr_o) + CTR_W'(1)));
  a_r11_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> $stable(ctr_o));
  a_r6_round_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> (rnd_q < nrnd_q));
  a_r7_rounds_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (nrnd_q != '0 && !nrnd_q[0] && nrnd_q <= MAX_R));
endmodule

// File: rtl/chacha_core.sv
module chacha_core
  import chacha_pkg::*;
#(
  parameter int unsigned ROUND_W    = 6,
  parameter int unsigned MAX_ROUNDS = 32,
  parameter int unsigned DEF_ROUNDS = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               init_i,
  input  logic               next_i,
  input  logic               key256_i,
  input  logic [KEY_W-1:0]   key_i,
  input  logic [IV_W-1:0]    iv_i,
  input  logic [CTR_W-1:0]   ctr_init_i,
  input  logic [ROUND_W-1:0] rounds_i,
  input  logic [BLOCK_W-1:0] data_i,
  output logic               ready_o,
  output logic [BLOCK_W-1:0] data_o,
  output logic               valid_o
);
  localparam int unsigned KEY_WORDS = KEY_W / WORD_W;
  localparam int unsigned KEY_BASE  = 4;
  localparam int unsigned CTR_BASE  = KEY_BASE + KEY_WORDS;
  localparam int unsigned IV_BASE   = CTR_BASE + CTR_W / WORD_W;

  logic             load, step, fin, diag, accept;
  logic [CTR_W-1:0] ctr;
  state_t           init_st, state_q, rnd_st, fin_st;
  logic             valid_q;
  logic [BLOCK_W-1:0] data_q;

  chacha_ctrl #(
    .ROUND_W(ROUND_W), .MAX_ROUNDS(MAX_ROUNDS), .DEF_ROUNDS(DEF_ROUNDS)
  ) u_ctrl (
    .clk_i, .rst_ni, .init_i, .next_i, .rounds_i, .ctr_init_i,
    .ready_o, .load_o(load), .step_o(step), .final_o(fin),
    .diag_o(diag), .ctr_o(ctr)
  );

  // initial state built from held inputs and the registered counter
  for (genvar w = 0; w < STATE_WORDS; w++) begin : g_init
    if (w < KEY_BASE) begin : g_const
      assign init_st[w] = key256_i ? CONST_K32[w] : CONST_K16[w];
    end else if (w < CTR_BASE) begin : g_key
      assign init_st[w] = key256_i ? key_i[WORD_W*(w-KEY_BASE) +: WORD_W]
                                   : key_i[WORD_W*((w-KEY_BASE)%4) +: WORD_W];
    end else if (w < IV_BASE) begin : g_ctr
      assign init_st[w] = ctr[WORD_W*(w-CTR_BASE) +: WORD_W];
    end else begin : g_iv
      assign init_st[w] = iv_i[WORD_W*(w-IV_BASE) +: WORD_W];
    end
  end

  chacha_round u_round (.st_i(state_q), .diag_i(diag), .st_o(rnd_st));

  for (genvar w = 0; w < STATE_WORDS; w++) begin : g_fin
    assign fin_st[w] = data_i[WORD_W*w +: WORD_W] ^ (state_q[w] + init_st[w]);
  end

  assign accept = ready_o & (init_i | next_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
    end else if (load) begin
      state_q <= init_st;
    end else if (step) begin
      state_q <= rnd_st;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else if (fin) begin
      data_q  <= fin_st;
      valid_q <= 1'b1;
    end else if (accept) begin
      valid_q <= 1'b0;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;

  a_r10_valid_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !accept) |=> (valid_o && $stable(data_o)));
  a_r10_valid_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !valid_o);
  a_r9_busy_after_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !ready_o);
  a_r9_valid_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ready_o);
  a_r9_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(fin));
endmodule

// File: tb/chacha_core_tb_top.sv
module chacha_core_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         init_r = 1'b0, next_r = 1'b0, k256_r = 1'b1;
  logic [255:0] key_r = '0;
  logic [63:0]  iv_r = '0, ctr_r = '0;
  logic [5:0]   rounds_r = 6'd8;
  logic [511:0] data_r = '0;
  logic         ready_o, valid_o;
  logic [511:0] data_o;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 0, vprev = 0;
  logic [63:0] exp_ctr = '0;

  typedef struct { logic [511:0] exp; int due; string tag; } item_t;
  item_t sb[$];

  logic [31:0] rx[16];
  logic [31:0] rs[16];

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  chacha_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init_r), .next_i(next_r),
    .key256_i(k256_r), .key_i(key_r), .iv_i(iv_r), .ctr_init_i(ctr_r),
    .rounds_i(rounds_r), .data_i(data_r), .ready_o(ready_o),
    .data_o(data_o), .valid_o(valid_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rl(input logic [31:0] v, input int n);
    return (v << n) | (v >> (32 - n));
  endfunction

  function automatic void rqr(input int a, input int b, input int c, input int d);
    rx[a] = rx[a] + rx[b]; rx[d] = rl(rx[d] ^ rx[a], 16);
    rx[c] = rx[c] + rx[d]; rx[b] = rl(rx[b] ^ rx[c], 12);
    rx[a] = rx[a] + rx[b]; rx[d] = rl(rx[d] ^ rx[a], 8);
    rx[c] = rx[c] + rx[d]; rx[b] = rl(rx[b] ^ rx[c], 7);
  endfunction

  function automatic int eff_rounds(input int r);
    return (r >= 2 && r <= 32 && r % 2 == 0) ? r : 8;
  endfunction

  // reference block from R2, R3, R4, R6, R8
  function automatic logic [511:0] ref_block(input logic [63:0] c, input int r);
    logic [511:0] res;
    rs[0] = 32'h61707865;
    rs[1] = k256_r ? 32'h3320646e : 32'h3120646e;
    rs[2] = k256_r ? 32'h79622d32 : 32'h79622d36;
    rs[3] = 32'h6b206574;
    for (int i = 0; i < 8; i++) rs[4+i] = k256_r ? key_r[32*i +: 32] : key_r[32*(i%4) +: 32];
    rs[12] = c[31:0];  rs[13] = c[63:32];
    rs[14] = iv_r[31:0]; rs[15] = iv_r[63:32];
    for (int i = 0; i < 16; i++) rx[i] = rs[i];
    for (int i = 0; i < r / 2; i++) begin
      rqr(0, 4, 8, 12); rqr(1, 5, 9, 13); rqr(2, 6, 10, 14); rqr(3, 7, 11, 15);
      rqr(0, 5, 10, 15); rqr(1, 6, 11, 12); rqr(2, 7, 8, 13); rqr(3, 4, 9, 14);
    end
    for (int i = 0; i < 16; i++) res[32*i +: 32] = data_r[32*i +: 32] ^ (rx[i] + rs[i]);
    return res;
  endfunction

  // driver: pushes the expected block and due cycle, then strobes
  task automatic issue(input bit do_init, input bit do_next, input int r, input string tag);
    int eff;
    while (!ready_o) @(negedge clk);
    rounds_r = r[5:0];
    eff = eff_rounds(r);
    if (do_init) exp_ctr = ctr_r; else exp_ctr = exp_ctr + 64'd1;
    sb.push_back('{ref_block(exp_ctr, eff), cyc + eff + 3, tag});
    init_r = do_init; next_r = do_next;
    @(negedge clk);
    init_r = 1'b0; next_r = 1'b0;
    chk(!ready_o, "R9", "ready low after take", 512'(ready_o), 512'(0));
    chk(!valid_o, "R10", "valid cleared on take", 512'(valid_o), 512'(0));
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!(ready_o && valid_o));
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid_o && !vprev) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R11", "unexpected result", data_o, '0);
        end else begin
          item_t it;
          it = sb.pop_front();
          chk(data_o == it.exp, it.tag, "result data", data_o, it.exp);
          chk(cyc == it.due, "R9", "result cycle", 512'(cyc), 512'(it.due));
        end
      end
      vprev = valid_o;
    end
  end

  initial begin
    logic [511:0] held;
    repeat (3) @(negedge clk);
    chk(ready_o === 1'b1, "R1", "reset ready", 512'(ready_o), 512'(1));
    chk(valid_o === 1'b0, "R1", "reset valid", 512'(valid_o), 512'(0));
    chk(data_o === '0, "R1", "reset data", data_o, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 fixed vector, all zero, 20 rounds
    issue(1, 0, 20, "R2");
    wait_done();
    chk(data_o[63:0] == 64'h903df1a0_ade0b876, "R2", "zero vector words 0..1",
        512'(data_o[63:0]), 512'(64'h903df1a0_ade0b876));

    // R4 R8 256-bit key, default rounds, patterned data
    for (int i = 0; i < 8; i++) key_r[32*i +: 32] = 32'h0f1e2d3c * (i + 1) ^ 32'h5a5a0000;
    iv_r = 64'hfeed_c0de_1234_5678;
    ctr_r = 64'h0000_0001_ffff_fffe;
    for (int i = 0; i < 16; i++) data_r[32*i +: 32] = (32'h1000_0001 * i) ^ 32'hdead_beef;
    issue(1, 0, 8, "R8");
    wait_done();
    // R5 consecutive blocks, carry into the high counter word
    issue(0, 1, 8, "R5");
    wait_done();
    issue(0, 1, 8, "R5");
    wait_done();

    // R10 hold then clear
    held = data_o;
    repeat (6) @(negedge clk);
    chk(valid_o && data_o == held, "R10", "result held", data_o, held);

    // R3 128-bit key, upper key bits are garbage
    k256_r = 1'b0;
    key_r[255:128] = {4{32'hbad0_f00d}};
    issue(1, 0, 12, "R3");
    wait_done();
    key_r[255:128] = ~key_r[255:128];
    issue(1, 0, 12, "R3");
    wait_done();
    k256_r = 1'b1;

    // R6 round extremes
    issue(1, 0, 2, "R6");
    wait_done();
    issue(1, 0, 32, "R6");
    wait_done();

    // R7 out-of-range settings fall back to 8
    issue(1, 0, 0, "R7");
    wait_done();
    issue(1, 0, 7, "R7");
    wait_done();
    issue(1, 0, 34, "R7");
    wait_done();

    // R11 strobes while busy are ignored
    issue(1, 0, 8, "R11");
    repeat (2) @(negedge clk);
    init_r = 1'b1; next_r = 1'b1;
    @(negedge clk);
    init_r = 1'b0; next_r = 1'b0;
    wait_done();
    issue(0, 1, 8, "R11");
    wait_done();
    // R11 init wins over next
    ctr_r = 64'h0123_4567_89ab_cdef;
    issue(1, 1, 8, "R11");
    wait_done();

    // R5 wrap of the 64-bit counter
    ctr_r = 64'hffff_ffff_ffff_ffff;
    issue(1, 0, 8, "R5");
    wait_done();
    issue(0, 1, 8, "R5");
    wait_done();

    repeat (5) @(negedge clk);
    chk(sb.size() == 0, "R9", "all results seen", 512'(sb.size()), 512'(0));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule